// File: doc/BRIEF.md
# Sideband Doorbell Mailbox Controller

This block gives a host processor a small register window through which it can run one register read or one register write at a time on a message-based sideband fabric. The host sets a target address and, for writes, a data word, then writes a command word into the doorbell register. That write launches a single request on the sideband port and raises a busy flag. The flag stays up until the endpoint answers. A read answer puts the returned word into the data register.

The command word carries the device/function, the opcode, the destination port, the byte enables and the BAR selector. Whether the request is a read or a write is worked out from the opcode. Power-management and north-cluster endpoints use opcode 6 for a read, and the display-PHY endpoint uses opcode 0 for a read. Both values mean a read, and every other opcode means a write.

The busy flag guards the transaction in flight. A second doorbell write is dropped while it is set, and a sticky error flag records the attempt. Writes to the address and data registers are also dropped while it is set.

Top module: `sb_mailbox`

## Requirements
- R1: After reset the doorbell, data, address and status registers all read 0, busy is 0 and req_valid is 0.
- R2: Register offsets are decoded from hst_addr[3:2]: doorbell 0x0, data 0x4, address 0x8, status 0xC. hst_rdata shows the selected register in the same cycle. The doorbell reads back as the latched command in bits 31:1 and busy in bit 0.
- R3: A doorbell write while busy is 0 does three things at the next edge: it latches bits 31:1, sets busy, and asserts req_valid. The fields are decoded as devfn = bits 31:24, opcode = 23:16, port = 15:8, byte enables = 7:4 and BAR = 3:1. req_addr is the address register.
- R4: When req_valid is 1 and req_ready is 0, req_valid and every request field hold their values until the handshake. req_valid drops in the cycle after req_valid and req_ready are both 1.
- R5: Opcodes 0 and 6 are reads: req_write is 0 and req_data is 0. Every other opcode is a write: req_write is 1 and req_data is the data register.
- R6: An accepted read response writes rsp_data into the data register on the same edge that clears busy.
- R7: An accepted write response clears busy and leaves the data register unchanged.
- R8: A doorbell write while busy is 1 is ignored: the latched command and the request are unchanged. It also sets status bit 0 (the sticky error flag).
- R9: Writing 1 to status bit 0 clears the error flag. Writing 0 to that bit leaves it set.
- R10: Writes to the data and address registers while busy is 1 are ignored.
- R11: rsp_valid is ignored unless a request has been handed off and its response is still outstanding. The data register and busy are unchanged.
- R12: After a transaction the data register can be rewritten (for example with 0). The next transaction then carries the new value and the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_addr | input | HOST_AW | Host byte offset in the window |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data for hst_addr |
| req_valid | output | 1 | Sideband request valid |
| req_ready | input | 1 | Sideband request accepted |
| req_write | output | 1 | 1 for a write request, 0 for a read |
| req_addr | output | SB_AW | Target register address |
| req_data | output | DATA_W | Write data; 0 for reads |
| req_devfn | output | 8 | Device/function field |
| req_opcode | output | 8 | Opcode field |
| req_port | output | 8 | Destination port field |
| req_be | output | 4 | Byte enables |
| req_bar | output | 3 | BAR selector |
| rsp_valid | input | 1 | Sideband response valid |
| rsp_data | input | DATA_W | Response data for reads |

## Verification
The assertions assume the following about the fabric:
- req_ready and rsp_valid are clean single-bit levels.
- A response comes only after the request handshake.
- The host issues at most one register write per cycle.

The stimulus keeps within this. It drives every input on the falling clock edge. It raises rsp_valid only after the handshake, apart from one deliberate stray pulse sent while the mailbox is idle to exercise the ignore rule. Stall windows are made by holding req_ready low for several cycles, never by dropping a request the block has already offered.

// File: rtl/sbmb_pkg.sv
package sbmb_pkg;

  // Command word bits 31:1; field order matches the doorbell bit layout.
  typedef struct packed {
    logic [7:0] devfn;   // 31:24
    logic [7:0] opcode;  // 23:16
    logic [7:0] port;    // 15:8
    logic [3:0] be;      // 7:4
    logic [2:0] bar;     // 3:1
  } sb_cmd_t;

  localparam int CMD_W = $bits(sb_cmd_t);

  typedef enum logic [1:0] {
    MB_IDLE = 2'd0,
    MB_REQ  = 2'd1,
    MB_WAIT = 2'd2
  } mb_state_t;

  // Word index of each register (hst_addr[3:2]).
  localparam logic [1:0] IDX_DOOR = 2'd0;
  localparam logic [1:0] IDX_DATA = 2'd1;
  localparam logic [1:0] IDX_ADDR = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  localparam logic [7:0] OPC_RD_PHY = 8'd0;
  localparam logic [7:0] OPC_RD_MGT = 8'd6;

  function automatic logic op_is_read(input logic [7:0] op);
    return (op == OPC_RD_PHY) || (op == OPC_RD_MGT);
  endfunction

  function automatic sb_cmd_t word_to_cmd(input logic [31:0] w);
    return sb_cmd_t'(w[31:1]);
  endfunction

  function automatic logic [31:0] cmd_to_word(input sb_cmd_t c, input logic busy);
    return {c, busy};
  endfunction

endpackage

// File: rtl/sbmb_hostdec.sv
module sbmb_hostdec
  import sbmb_pkg::*;
#(
  parameter int HOST_AW = 4,
  parameter int DATA_W  = 32,
  parameter int SB_AW   = 32
) (
  input  logic               wr_en,
  input  logic [HOST_AW-1:0] addr,
  input  logic               busy,
  output logic               door_go,
  output logic               door_rej,
  output logic               data_we,
  output logic               addr_we,
  output logic               stat_we,
  input  sb_cmd_t            cmd_q,
  input  logic [DATA_W-1:0]  data_q,
  input  logic [SB_AW-1:0]   addr_q,
  input  logic               err_q,
  output logic [DATA_W-1:0]  rdata
);

  logic [1:0] idx;
  logic [3:0] hit;

  assign idx = addr[3:2];

  for (genvar g = 0; g < 4; g++) begin : g_hit
    assign hit[g] = wr_en && (idx == 2'(g));
  end

  assign door_go  = hit[IDX_DOOR] && !busy;
  assign door_rej = hit[IDX_DOOR] &&  busy;
  assign data_we  = hit[IDX_DATA] && !busy;
  assign addr_we  = hit[IDX_ADDR] && !busy;
  assign stat_we  = hit[IDX_STAT];

  always_comb begin
    unique case (idx)
      IDX_DOOR: rdata = DATA_W'(cmd_to_word(cmd_q, busy));
      IDX_DATA: rdata = data_q;
      IDX_ADDR: rdata = DATA_W'(addr_q);
      default:  rdata = DATA_W'(err_q);
    endcase
  end

endmodule

// File: rtl/sbmb_seq.sv
module sbmb_seq
  import sbmb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic busy,
  output logic req_valid,
  output logic req_hs,
  output logic rsp_accept
);

  mb_state_t st_q, st_d;

  assign busy       = (st_q != MB_IDLE);
  assign req_valid  = (st_q == MB_REQ);
  assign req_hs     = req_valid && req_ready;
  assign rsp_accept = (st_q == MB_WAIT) && rsp_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MB_IDLE: if (launch)     st_d = MB_REQ;
      MB_REQ:  if (req_ready)  st_d = MB_WAIT;
      MB_WAIT: if (rsp_valid)  st_d = MB_IDLE;
      default:                 st_d = MB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= MB_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/sbmb_regfile.sv
module sbmb_regfile
  import sbmb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SB_AW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              door_go,
  input  logic              door_rej,
  input  logic              data_we,
  input  logic              addr_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rsp_accept,
  input  logic [DATA_W-1:0] rsp_data,
  output sb_cmd_t           cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic [SB_AW-1:0]  addr_q,
  output logic              err_q,
  output logic              rd_q
);

  assign rd_q = op_is_read(cmd_q.opcode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (door_go) begin
      cmd_q <= word_to_cmd(32'(wdata));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_we) begin
      addr_q <= wdata[SB_AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rsp_accept && rd_q) begin
      data_q <= rsp_data;
    end else if (data_we) begin
      data_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (door_rej) begin
      err_q <= 1'b1;
    end else if (stat_we && wdata[0]) begin
      err_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sb_mailbox.sv
module sb_mailbox
  import sbmb_pkg::*;
#(
  parameter int HOST_AW = 4,
  parameter int DATA_W  = 32,
  parameter int SB_AW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_wr_en,
  input  logic [HOST_AW-1:0] hst_addr,
  input  logic [DATA_W-1:0]  hst_wdata,
  output logic [DATA_W-1:0]  hst_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_write,
  output logic [SB_AW-1:0]   req_addr,
  output logic [DATA_W-1:0]  req_data,
  output logic [7:0]         req_devfn,
  output logic [7:0]         req_opcode,
  output logic [7:0]         req_port,
  output logic [3:0]         req_be,
  output logic [2:0]         req_bar,
  input  logic               rsp_valid,
  input  logic [DATA_W-1:0]  rsp_data
);

  // Named internal events, visible to the bound checker.
  logic              busy;
  logic              launch_evt;
  logic              reject_evt;
  logic              rsp_accept;
  logic              req_hs;
  logic              data_we, addr_we, stat_we;
  logic              err_q;
  logic              rd_q;
  sb_cmd_t           cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [SB_AW-1:0]  addr_q;

  sbmb_hostdec #(.HOST_AW(HOST_AW), .DATA_W(DATA_W), .SB_AW(SB_AW)) u_dec (
    .wr_en    (hst_wr_en),
    .addr     (hst_addr),
    .busy     (busy),
    .door_go  (launch_evt),
    .door_rej (reject_evt),
    .data_we  (data_we),
    .addr_we  (addr_we),
    .stat_we  (stat_we),
    .cmd_q    (cmd_q),
    .data_q   (data_q),
    .addr_q   (addr_q),
    .err_q    (err_q),
    .rdata    (hst_rdata)
  );

  sbmb_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch_evt),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .busy       (busy),
    .req_valid  (req_valid),
    .req_hs     (req_hs),
    .rsp_accept (rsp_accept)
  );

  sbmb_regfile #(.DATA_W(DATA_W), .SB_AW(SB_AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .door_go    (launch_evt),
    .door_rej   (reject_evt),
    .data_we    (data_we),
    .addr_we    (addr_we),
    .stat_we    (stat_we),
    .wdata      (hst_wdata),
    .rsp_accept (rsp_accept),
    .rsp_data   (rsp_data),
    .cmd_q      (cmd_q),
    .data_q     (data_q),
    .addr_q     (addr_q),
    .err_q      (err_q),
    .rd_q       (rd_q)
  );

  assign req_write  = !rd_q;
  assign req_data   = rd_q ? '0 : data_q;
  assign req_addr   = addr_q;
  assign req_devfn  = cmd_q.devfn;
  assign req_opcode = cmd_q.opcode;
  assign req_port   = cmd_q.port;
  assign req_be     = cmd_q.be;
  assign req_bar    = cmd_q.bar;

endmodule

// File: rtl/sb_mailbox_chk.sv
module sb_mailbox_chk #(
  parameter int DATA_W = 32,
  parameter int SB_AW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              launch_evt,
  input logic              reject_evt,
  input logic              rsp_accept,
  input logic              err_q,
  input logic [DATA_W-1:0] data_q,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [SB_AW-1:0]  req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic [7:0]        req_opcode,
  input logic [7:0]        req_port,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data
);

  // R3
  launch_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> busy && req_valid);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_opcode) && $stable(req_port) && $stable(req_data));

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid && busy);

  // R5
  read_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |-> req_data == '0);

  // R6
  read_rsp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept && !req_write |=> !busy && data_q == $past(rsp_data));

  // R7
  write_rsp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept && req_write |=> !busy && $stable(data_q));

  // R8
  reject_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> err_q && $stable(req_opcode) && $stable(req_addr));

  // R11
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !busy && !launch_evt |=> !busy && $stable(data_q));

endmodule

bind sb_mailbox sb_mailbox_chk #(.DATA_W(DATA_W), .SB_AW(SB_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .launch_evt (launch_evt),
  .reject_evt (reject_evt),
  .rsp_accept (rsp_accept),
  .err_q      (err_q),
  .data_q     (data_q),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_data   (req_data),
  .req_opcode (req_opcode),
  .req_port   (req_port),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data)
);

// File: tb/sb_mailbox_test.sv
module sb_mailbox_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr_en = 1'b0;
  logic [3:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        req_valid, req_write;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr, req_data;
  logic [7:0]  req_devfn, req_opcode, req_port;
  logic [3:0]  req_be;
  logic [2:0]  req_bar;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sb_mailbox uut (.*);

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  port;
    logic [7:0]  devfn;
    logic [31:0] addr;
    logic [31:0] wdat;
    logic [31:0] rdat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd6, 8'h04, 8'h10, 32'h0000_00d8, 32'h1111_1111, 32'h1234_5678},
    '{8'd7, 8'h04, 8'h10, 32'h0000_00d4, 32'hcafe_0001, 32'hffff_0000},
    '{8'd6, 8'h11, 8'h10, 32'h0000_001c, 32'h2222_2222, 32'h0007_f800},
    '{8'd0, 8'h12, 8'h00, 32'h0000_8010, 32'h3333_3333, 32'ha5a5_5a5a},
    '{8'd1, 8'h12, 8'h00, 32'h0000_8014, 32'h0000_00ff, 32'h0bad_0bad},
    '{8'd3, 8'h12, 8'h00, 32'h0000_0020, 32'hffff_ffff, 32'h0000_0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] off, input logic [31:0] val);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_addr = off; hst_wdata = val;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [3:0] off, output logic [31:0] val);
    hst_addr = off;
    #1 val = hst_rdata;
  endtask

  function automatic logic [31:0] door_word(input vec_t v);
    return {v.devfn, v.op, v.port, 4'hf, 3'b000, 1'b0};
  endfunction

  // Hand off the pending request, then answer it.
  task automatic finish_txn(input logic [31:0] rdat);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk("R4 valid drops after handshake", {31'd0, req_valid}, 32'd0);
    rsp_valid = 1'b1; rsp_data = rdat;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic        exp_wr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      hread(4'(i * 4), rv);
      chk("R1 reset register", rv, 32'd0);
    end
    chk("R1 reset req_valid", {31'd0, req_valid}, 32'd0);

    // R11 stray response while idle
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = 32'hdead_beef;
    @(negedge clk);
    rsp_valid = 1'b0;
    hread(4'h4, rv); chk("R11 stray rsp data", rv, 32'd0);
    hread(4'h0, rv); chk("R11 stray rsp busy", rv, 32'd0);

    // Vector table
    for (int k = 0; k < 6; k++) begin
      exp_wr = !(VECS[k].op == 8'd0 || VECS[k].op == 8'd6);
      hwrite(4'h8, VECS[k].addr);
      hwrite(4'h4, VECS[k].wdat);
      hread(4'h8, rv); chk("R2 address readback", rv, VECS[k].addr);
      hwrite(4'h0, door_word(VECS[k]));
      chk("R3 req_valid", {31'd0, req_valid}, 32'd1);
      chk("R3 opcode", {24'd0, req_opcode}, {24'd0, VECS[k].op});
      chk("R3 port", {24'd0, req_port}, {24'd0, VECS[k].port});
      chk("R3 devfn", {24'd0, req_devfn}, {24'd0, VECS[k].devfn});
      chk("R3 be/bar", {25'd0, req_be, req_bar}, {25'd0, 4'hf, 3'd0});
      chk("R3 addr", req_addr, VECS[k].addr);
      chk("R5 req_write", {31'd0, req_write}, {31'd0, exp_wr});
      chk("R5 req_data", req_data, exp_wr ? VECS[k].wdat : 32'd0);
      hread(4'h0, rv); chk("R2 doorbell readback busy", rv, door_word(VECS[k]) | 32'd1);
      finish_txn(VECS[k].rdat);
      hread(4'h0, rv); chk("R6/R7 busy cleared", {31'd0, rv[0]}, 32'd0);
      hread(4'h4, rv);
      if (exp_wr) chk("R7 data kept", rv, VECS[k].wdat);
      else        chk("R6 data loaded", rv, VECS[k].rdat);
    end

    // R12 clearing data, next transaction uses new values
    hwrite(4'h4, 32'd0);
    hwrite(4'h8, 32'h0000_0044);
    hwrite(4'h0, door_word(VECS[1]));
    chk("R12 new data", req_data, 32'd0);
    chk("R12 new addr", req_addr, 32'h44);
    finish_txn(32'd0);

    // R4 stall hold, R8 reject, R10 busy-protected registers
    hwrite(4'h8, 32'h0000_00aa);
    hwrite(4'h4, 32'h5555_0000);
    hwrite(4'h0, door_word(VECS[0]));
    repeat (3) @(negedge clk);
    chk("R4 held valid", {31'd0, req_valid}, 32'd1);
    chk("R4 held addr", req_addr, 32'haa);
    hwrite(4'h0, door_word(VECS[4]));
    hread(4'h0, rv); chk("R8 doorbell unchanged", rv, door_word(VECS[0]) | 32'd1);
    chk("R8 opcode unchanged", {24'd0, req_opcode}, 32'd6);
    hread(4'hc, rv); chk("R8 error set", rv, 32'd1);
    hwrite(4'h8, 32'h0000_0bbb);
    hwrite(4'h4, 32'h7777_7777);
    hread(4'h8, rv); chk("R10 addr ignored", rv, 32'haa);
    hread(4'h4, rv); chk("R10 data ignored", rv, 32'h5555_0000);
    finish_txn(32'h0f0f_0f0f);
    hread(4'h4, rv); chk("R6 data after stall", rv, 32'h0f0f_0f0f);

    // R9 clear semantics
    hwrite(4'hc, 32'd0);
    hread(4'hc, rv); chk("R9 write 0 keeps error", rv, 32'd1);
    hwrite(4'hc, 32'd1);
    hread(4'hc, rv); chk("R9 write 1 clears error", rv, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule